// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the column addresses the burst visits. A request gives a start column, a 3-bit length code and an ordering bit. The block latches all three when `start_i` is high. From the next cycle it presents one column per beat on `col_o`, with `valid_o` high. A beat is taken in any cycle where `adv_i` is high, and the next column follows on the cycle after.

Bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block that holds the start column. Sequential order counts upward and wraps inside that block. Interleaved order XORs the beat index into the low bits of the start column. A full-row burst counts upward across the whole row and wraps from the last column to column 0. It ends only when `stop_i` is raised. `last_o` marks the final beat of every burst.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_ni` is low, and after reset until a start, `valid_o` and `last_o` are 0.
- R2: A cycle with `start_i` high latches the request. The next cycle shows `valid_o`=1 and `col_o` equal to the start column. A start during an active burst abandons that burst and begins the new one.
- R3: While `valid_o`=1 and `adv_i`=0, `col_o` and `valid_o` hold their values.
- R4: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `last_o` is high exactly on the final beat. After that beat is taken, `valid_o` drops to 0.
- R5: With ordering bit 0 (sequential), beat i is at column (aligned block base) + ((start offset in block + i) mod length). The column bits above the block are unchanged. Start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R6: With ordering bit 1 (interleaved), beat i is at column start XOR i. Start 5 with 4 beats gives 5,4,7,6.
- R7: For lengths 1 and 2 both orderings give the same sequence. A block-aligned start gives ascending columns in both orderings.
- R8: Length code 3'b111 is a full-row burst. Columns rise by one per beat and wrap from the top column of the row to 0. `last_o` follows `stop_i` while `valid_o` is high, and the burst ends at the edge where `stop_i` is high.
- R9: A full-row burst requested with ordering bit 1 runs in sequential order.
- R10: Reserved length codes 3'b100 to 3'b110 give a 1-beat burst.
- R11: `stop_i` has no effect during a burst of length code 3'b000 to 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Latch a new burst request |
| start_col_i | input | COL_W | Start column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| adv_i | input | 1 | Take the current beat |
| stop_i | input | 1 | End a full-row burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Current beat is the final one |

## Verification
The bench builds the block with COL_W=5, a 32-column row instead of the default 2048. With that row, a full-row burst reaches the wrap from column 31 to 0 in a few beats. A 5-bit column also has bits above the 8-column block, so the bench can check that sequential and interleaved bursts leave those upper bits unchanged. Every block-bounded burst behaves the same at this width as at the default one.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_FULL = 3'b111
  } len_code_e;

  // low-bit mask (length - 1) for bounded bursts; reserved codes map to length 1
  function automatic logic [2:0] low_mask(input logic [2:0] code);
    case (code)
      LEN_2:   return 3'b001;
      LEN_4:   return 3'b011;
      LEN_8:   return 3'b111;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
  import burst_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic [2:0]       code_i,
  input  logic             il_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             il_o
);
  always_comb begin
    full_o = (code_i == LEN_FULL);
    mask_o = full_o ? {COL_W{1'b1}} : COL_W'(low_mask(code_i));
    il_o   = il_i & ~full_o;   // full row runs sequential only
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 11
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  always_comb begin
    sum = base_i + cnt_i;
    if (il_i) col_o = base_i ^ (cnt_i & mask_i);
    else      col_o = (base_i & ~mask_i) | (sum & mask_i);
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             il_i,
  input  logic             adv_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             il_o
);
  logic             active_q, full_q, il_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic             last, take, finish;

  always_comb begin
    last   = active_q & (full_q ? stop_i : ((cnt_q & mask_q) == mask_q));
    take   = active_q & adv_i;
    finish = (take & last) | (active_q & full_q & stop_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      il_q     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_i;
      il_q     <= il_i;
      base_q   <= start_col_i;
      cnt_q    <= '0;
      mask_q   <= mask_i;
    end else begin
      if (finish)    active_q <= 1'b0;
      else if (take) cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = last;
  assign base_o   = base_q;
  assign cnt_o    = cnt_q;
  assign mask_o   = mask_q;
  assign il_o     = il_q;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             adv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask, st_mask, st_base, st_cnt;
  logic             dec_full, dec_il, st_il;

  burst_len_dec #(.COL_W(COL_W)) u_dec (
    .code_i (len_code_i),
    .il_i   (interleave_i),
    .mask_o (dec_mask),
    .full_o (dec_full),
    .il_o   (dec_il)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .il_i        (dec_il),
    .adv_i       (adv_i),
    .stop_i      (stop_i),
    .active_o    (valid_o),
    .last_o      (last_o),
    .base_o      (st_base),
    .cnt_o       (st_cnt),
    .mask_o      (st_mask),
    .il_o        (st_il)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i (st_base),
    .cnt_i  (st_cnt),
    .mask_i (st_mask),
    .il_i   (st_il),
    .col_o  (col_o)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       len_code_i,
  input logic             adv_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  p_idle_no_last_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !last_o);

  p_start_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !adv_i && !start_i && !stop_i) |=> (valid_o && $stable(col_o)));

  p_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && adv_i && last_o && !start_i) |=> !valid_o);

  p_cont_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && adv_i && !last_o && !start_i) |=> valid_o);

  p_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (len_code_i == 3'b000 || len_code_i == 3'b100 ||
                 len_code_i == 3'b101 || len_code_i == 3'b110)) |=> last_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .len_code_i (len_code_i),
  .adv_i      (adv_i),
  .stop_i     (stop_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  localparam int COL_W  = 5;
  localparam int ROW    = 1 << COL_W;
  localparam int PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             interleave_i = 1'b0;
  logic             adv_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  logic [COL_W:0] exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .adv_i(adv_i),
    .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int len, bit il, bit full, int i);
    int base;
    if (full) return (s + i) % ROW;
    if (il) return s ^ i;
    base = s - (s % len);
    return base + ((s % len + i) % len);
  endfunction

  // monitor: every taken beat is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o && adv_i) begin
      if (exp_q.size() == 0) begin
        check({cur_req, " unexpected beat"}, 1, 0);
      end else begin
        logic [COL_W:0] e;
        e = exp_q.pop_front();
        check({cur_req, " col"}, int'(col_o), int'(e[COL_W-1:0]));
        check({cur_req, " last"}, int'(last_o), int'(e[COL_W]));
      end
    end
  end

  // take=0: run the whole burst; bounded take<len abandons it
  task automatic run_burst(input string req, input int s, input int code,
                           input bit il, input int take, input bit hold,
                           input bit stop_mid);
    bit full;
    int len, n;
    bit done;
    full = (code == 7);
    len  = (code <= 3) ? (1 << code) : 1;
    n    = full ? take : ((take == 0 || take > len) ? len : take);
    done = full || (n == len);
    for (int i = 0; i < n; i++)
      exp_q.push_back({(full ? (i == n-1) : (i == len-1)) ? 1'b1 : 1'b0,
                       COL_W'(exp_col(s, len, il, full, i))});
    @(posedge clk); #1;
    cur_req = req;
    start_i = 1'b1; start_col_i = COL_W'(s); len_code_i = 3'(code);
    interleave_i = il; adv_i = 1'b0; stop_i = 1'b0;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (hold) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R3 hold col", int'(col_o), exp_col(s, len, il, full, 0));
        check("R3 hold valid", int'(valid_o), 1);
        @(posedge clk); #1;
      end
    end
    for (int i = 0; i < n; i++) begin
      adv_i  = 1'b1;
      stop_i = (full && i == n-1) || (stop_mid && i == 0);
      @(posedge clk); #1;
    end
    adv_i = 1'b0; stop_i = 1'b0;
    @(negedge clk);
    if (done) check({req, " valid after end"}, int'(valid_o), 0);
    check({req, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD*2 + 2);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 last in reset", int'(last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(valid_o), 0);

    run_burst("R2_R5 seq8 s5", 5, 3, 1'b0, 0, 1'b1, 1'b0);
    run_burst("R5 seq8 upper bits", 13, 3, 1'b0, 0, 1'b0, 1'b0);
    run_burst("R6 il4 s5", 5, 2, 1'b1, 0, 1'b0, 1'b0);
    run_burst("R6 il8 s21", 21, 3, 1'b1, 0, 1'b0, 1'b0);
    run_burst("R7 len2 il", 7, 1, 1'b1, 0, 1'b0, 1'b0);
    run_burst("R7 len2 seq", 7, 1, 1'b0, 0, 1'b0, 1'b0);
    run_burst("R7 aligned il", 8, 3, 1'b1, 0, 1'b0, 1'b0);
    run_burst("R4 len1", 19, 0, 1'b0, 0, 1'b0, 1'b0);
    run_burst("R4 seq4 s2", 2, 2, 1'b0, 0, 1'b0, 1'b0);
    run_burst("R8 full wrap", 28, 7, 1'b0, 8, 1'b1, 1'b0);
    run_burst("R9 full il", 29, 7, 1'b1, 6, 1'b0, 1'b0);
    run_burst("R10 code5", 11, 5, 1'b1, 0, 1'b0, 1'b0);
    run_burst("R10 code6", 12, 6, 1'b0, 0, 1'b0, 1'b0);
    run_burst("R11 stop ignored", 3, 2, 1'b0, 0, 1'b0, 1'b1);
    run_burst("R2 abandoned", 1, 3, 1'b0, 3, 1'b0, 1'b0);
    run_burst("R2 restart", 26, 2, 1'b1, 0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule